// File: doc/BRIEF.md
# Programmable Baud Enable Generator

This block turns the system clock into a stream of single-cycle enable pulses whose spacing is set by a 16-bit divisor. A serial transmitter uses the pulse to time its bit cells, and a serial receiver uses the same pulse to time its line sampling. The pulse is a qualifier inside the one clock domain (`if (baud_en) ...`), never a clock, so no second clock domain comes into being.

A processor loads the divisor one byte at a time. Its bus decoder turns an access at bus address 2'b10 into the low-byte strobe and an access at 2'b11 into the high-byte strobe. A down counter counts from the divisor to zero. On the cycle after it reaches zero, the block raises the enable and reloads the counter, so one period lasts divisor + 1 clock cycles. Writing the high byte restarts the counter at once, so the new rate applies without waiting for the old count to run out. The usual order is low byte first and high byte last.

Top module: `baud_enable_gen`

## Requirements
- R1: While reset is asserted `baud_en` is 0. Reset loads the divisor and the counter with the parameter `DEFAULT_DIV`, so with a nonzero default the first pulse comes DEFAULT_DIV + 1 cycles after the first clock edge with reset released.
- R2: With a nonzero divisor D, `baud_en` is high for exactly one cycle and the rising edges are D + 1 cycles apart. With D = 1 the output is high every other cycle.
- R3: A strobe on `div_lo_we` alone replaces bits 7:0 of the divisor with `wr_data`. It leaves the running count alone, so the period in progress ends on the old timing and the new divisor is used from the next reload.
- R4: A strobe on `div_hi_we` replaces bits 15:8 of the divisor with `wr_data` and reloads the counter from the whole new divisor in the same edge. The next pulse follows D + 1 cycles after that edge.
- R5: While the divisor is 0, `baud_en` stays 0.
- R6: When both strobes are high in the same cycle, both bytes of the divisor take `wr_data`, and the counter reloads from that value.
- R7: A high-byte write in the cycle where the counter stands at zero cancels the pulse that would have followed. Timing restarts from the new divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_lo_we | input | 1 | Write strobe for divisor bits 7:0 (bus address 2'b10) |
| div_hi_we | input | 1 | Write strobe for divisor bits 15:8 (bus address 2'b11), also restarts the counter |
| wr_data | input | 8 | Byte to be written into the divisor |
| baud_en | output | 1 | Single-cycle enable pulse |

## Verification
The bound checker watches, on every cycle, that a pulse never lasts beyond one cycle. It also checks that a zero divisor or a high-byte write keeps the next cycle quiet, that a low-byte write alone lets the count keep stepping down, and that a double strobe writes the byte into both halves. The exact pulse spacing for a given divisor, the handover from old to new divisor after a low-byte write, and the first pulse after reset depend on the history of several writes. Only the bench's reference model and its gap measurements, driven through the chosen write sequences, can show these.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int DIV_W  = BYTE_W * LANES;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [DIV_W-1:0]  div_t;

    typedef struct packed {
        div_t value;
    } div_state_t;

    typedef struct packed {
        div_t cnt;
        logic en;
    } tick_state_t;
endpackage

// File: rtl/baud_div_reg.sv
module baud_div_reg
    import baud_gen_pkg::*;
#(
    parameter div_t RESET_DIV = div_t'(27)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_we,
    input  byte_t            wr_data,
    output div_t             div_q_o,
    output div_t             div_d_o
);
    div_state_t st_d, st_q;
    byte_t      lane_nxt [LANES];

    // one byte lane per strobe
    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        assign lane_nxt[gi] = lane_we[gi] ? wr_data
                                          : st_q.value[gi*BYTE_W +: BYTE_W];
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < LANES; i++) begin
            st_d.value[i*BYTE_W +: BYTE_W] = lane_nxt[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.value <= RESET_DIV;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_q_o = st_q.value;
    assign div_d_o = st_d.value;
endmodule

// File: rtl/baud_tick_counter.sv
module baud_tick_counter
    import baud_gen_pkg::*;
#(
    parameter div_t RESET_DIV = div_t'(27)
) (
    input  logic clk,
    input  logic rst_n,
    input  div_t div_cur,
    input  div_t div_nxt,
    input  logic restart,
    output logic tick,
    output div_t cnt_o
);
    tick_state_t st_d, st_q;
    logic        at_zero;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.cnt == '0);
        st_d.en = at_zero && (div_cur != '0) && !restart;
        if (restart) begin
            st_d.cnt = div_nxt;
        end else if (at_zero) begin
            st_d.cnt = div_cur;
        end else begin
            st_d.cnt = st_q.cnt - div_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= RESET_DIV;
            st_q.en  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick  = st_q.en;
    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/baud_enable_gen.sv
module baud_enable_gen
    import baud_gen_pkg::*;
#(
    parameter div_t DEFAULT_DIV = div_t'(27)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       div_lo_we,
    input  logic       div_hi_we,
    input  logic [7:0] wr_data,
    output logic       baud_en
);
    logic [LANES-1:0] lane_we;
    div_t             div_q;
    div_t             div_d;
    div_t             cnt_q;

    assign lane_we = {div_hi_we, div_lo_we};

    baud_div_reg #(
        .RESET_DIV (DEFAULT_DIV)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (lane_we),
        .wr_data (wr_data),
        .div_q_o (div_q),
        .div_d_o (div_d)
    );

    baud_tick_counter #(
        .RESET_DIV (DEFAULT_DIV)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_cur (div_q),
        .div_nxt (div_d),
        .restart (lane_we[LANES-1]),
        .tick    (baud_en),
        .cnt_o   (cnt_q)
    );
endmodule

// File: rtl/baud_enable_gen_chk.sv
module baud_enable_gen_chk
    import baud_gen_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  div_lo_we,
    input logic  div_hi_we,
    input byte_t wr_data,
    input logic  baud_en,
    input div_t  div_q,
    input div_t  cnt_q
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !baud_en);

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_en |=> !baud_en);

    // R5
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) |=> !baud_en);

    // R7
    hi_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_hi_we |=> !baud_en);

    // R3
    lo_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_lo_we && !div_hi_we && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - div_t'(1)));

    // R6
    both_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_lo_we && div_hi_we) |=> (div_q == {$past(wr_data), $past(wr_data)} && cnt_q == div_q));
endmodule

bind baud_enable_gen baud_enable_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_lo_we (div_lo_we),
    .div_hi_we (div_hi_we),
    .wr_data   (wr_data),
    .baud_en   (baud_en),
    .div_q     (div_q),
    .cnt_q     (cnt_q)
);

// File: tb/baud_enable_gen_bench.sv
module baud_enable_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEF_DIV    = 27;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_lo_we = 1'b0;
    logic       div_hi_we = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_en;

    int    checks = 0;
    int    errors = 0;
    int    cycle  = 0;
    string cur_req = "R1";

    // behavioural reference model
    int ref_div = DEF_DIV;
    int ref_cnt = DEF_DIV;
    bit ref_en  = 1'b0;

    baud_enable_gen #(.DEFAULT_DIV(16'(DEF_DIV))) u_baud_enable_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_lo_we (div_lo_we),
        .div_hi_we (div_hi_we),
        .wr_data   (wr_data),
        .baud_en   (baud_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_div = DEF_DIV;
            ref_cnt = DEF_DIV;
            ref_en  = 1'b0;
        end else begin
            int new_div;
            new_div = ref_div;
            if (div_lo_we) new_div = (new_div & 32'hFF00) | int'(wr_data);
            if (div_hi_we) new_div = (new_div & 32'h00FF) | (int'(wr_data) << 8);
            ref_en = (ref_cnt == 0) && (ref_div != 0) && !div_hi_we;
            if (div_hi_we)          ref_cnt = new_div;
            else if (ref_cnt == 0)  ref_cnt = ref_div;
            else                    ref_cnt = ref_cnt - 1;
            ref_div = new_div;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        cycle++;
        check(cur_req, int'(baud_en), int'(ref_en), "baud_en vs model");
        if (cycle > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycle, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input bit lo, input bit hi, input logic [7:0] d);
        @(negedge clk);
        div_lo_we = lo; div_hi_we = hi; wr_data = d;
        @(negedge clk);
        div_lo_we = 1'b0; div_hi_we = 1'b0; wr_data = 8'h00;
    endtask

    // returns cycles between two rising pulses
    task automatic gap(output int g);
        do @(negedge clk); while (!baud_en);
        g = 0;
        do begin @(negedge clk); g++; end while (!baud_en);
    endtask

    initial begin
        int g;
        int n;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", int'(baud_en), 0, "baud_en in reset");
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!baud_en && n < 200);
        check("R1", n, DEF_DIV + 1, "cycles to first pulse");

        // R4/R2: load 5, restart
        cur_req = "R4";
        wr(1, 0, 8'd5);
        @(negedge clk); div_hi_we = 1'b1; wr_data = 8'd0;
        n = 0;
        @(negedge clk); div_hi_we = 1'b0;
        do begin n++; @(negedge clk); end while (!baud_en && n < 200);
        check("R4", n, 6, "cycles from hi write to pulse");
        cur_req = "R2";
        for (int i = 0; i < 3; i++) begin gap(g); check("R2", g, 6, "gap div=5"); end
        wr(1, 0, 8'd1); wr(0, 1, 8'd0);
        for (int i = 0; i < 3; i++) begin gap(g); check("R2", g, 2, "gap div=1"); end

        // R3: low byte only, mid-count
        cur_req = "R3";
        wr(1, 0, 8'd9); wr(0, 1, 8'd0);
        repeat (3) @(negedge clk);
        wr(1, 0, 8'd12);
        gap(g);
        gap(g); check("R3", g, 13, "gap after low-byte change");

        // R7: high write while counter sits at zero
        cur_req = "R7";
        while (!(ref_cnt == 0)) @(negedge clk);
        div_hi_we = 1'b1; wr_data = 8'd0;
        @(negedge clk);
        div_hi_we = 1'b0;
        check("R7", int'(baud_en), 0, "pulse cancelled");
        gap(g); check("R7", g, 13, "gap after restart");

        // R6: both strobes -> 0x0101
        cur_req = "R6";
        wr(1, 1, 8'd1);
        gap(g); check("R6", g, 258, "gap div=0x0101");

        // R5: zero divisor
        cur_req = "R5";
        wr(1, 0, 8'd0); wr(0, 1, 8'd0);
        n = 0;
        for (int i = 0; i < 80; i++) begin @(negedge clk); if (baud_en) n++; end
        check("R5", n, 0, "pulses with zero divisor");
        cur_req = "R4";
        wr(1, 0, 8'd3); wr(0, 1, 8'd0);
        gap(g); check("R4", g, 4, "gap after leaving zero");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule